// File: doc/BRIEF.md
# NAND Logical-Unit Operation Sequencer

This block is the device-side control model of a single NAND logical unit. A front end has already split the host bus into command events and address events. The sequencer follows the two-opcode handshakes for page read, page program and block erase. It collects the address bytes that sit between the two opcodes. When a legal closing opcode arrives, it starts a timed busy period. The closing opcode selects single-plane or multi-plane operation.

While the unit is busy, the ready/busy output is low, and every command and address event is dropped. When the busy period ends, the unit returns to idle and waits for the next opening opcode. The write-protect input blocks program and erase. Attempting either one while protected does not start any busy period; it sets a fail flag in the status byte instead. The block reports the kind of the last operation it started, its plane mode and its row address. No array storage and no data transfer are modelled.

Top module: `nand_lun_seq`

## Requirements
- R1: After reset, `rb_n` is 1, `op_kind` is 0 (none), `op_multi` is 0, `op_row` is 0 and `status[0]` is 0.
- R2: Opcode 00h, then COL_BYTES column bytes and ROW_BYTES row bytes, then 30h starts a read with `op_kind`=1 and `op_multi`=0. Ending the same sequence with 32h instead starts a read with `op_multi`=1.
- R3: Opcode 80h, then the same column and row bytes, then 10h starts a single-plane program (`op_kind`=2, `op_multi`=0). Ending with 11h starts a multi-plane program (`op_multi`=1).
- R4: Opcode 60h, then ROW_BYTES row bytes and no column bytes, then D0h starts a single-plane erase (`op_kind`=3, `op_multi`=0). Ending with D1h starts a multi-plane erase (`op_multi`=1).
- R5: `rb_n` goes low in the cycle after the closing opcode is sampled. It stays low for exactly READ_CYC, PROG_CYC or ERASE_CYC cycles, according to the operation, and then returns to 1.
- R6: While `rb_n` is 0, command and address events are ignored. `op_kind`, `op_multi` and `op_row` hold their values, and no sequence left open from that time can later be completed.
- R7: In a pending sequence, a closing opcode that belongs to a different operation, or any unknown opcode, returns the unit to idle without starting anything. An opening opcode always starts a new sequence.
- R8: A matching closing opcode that arrives before all required address bytes have been received aborts the sequence without starting an operation.
- R9: A program or erase that is closed while `wp_n` is 0 starts no busy period and leaves the operation outputs unchanged. It sets `status[0]`. A read is still performed under write protect.
- R10: `status[7]` follows `wp_n` with one cycle of delay. `status[6]` and `status[5]` are 1 exactly when `rb_n` is 1. Bits 4..1 are 0. `status[0]` is cleared whenever an operation starts.
- R11: Row byte k of the sequence (k counted from 0 after the column bytes) lands in `op_row[8k+7:8k]`. Address bytes beyond the required count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_code | input | 8 | Command opcode |
| addr_valid | input | 1 | An address byte is present this cycle (ignored while `cmd_valid` is 1) |
| addr_byte | input | 8 | Address byte |
| wp_n | input | 1 | Write protect, active low |
| rb_n | output | 1 | Ready (1) / busy (0) |
| op_kind | output | 2 | Last started operation: 0 none, 1 read, 2 program, 3 erase |
| op_multi | output | 1 | Last started operation was multi-plane |
| op_row | output | 8*ROW_BYTES | Row address of the last started operation |
| status | output | 8 | Status byte: [7] not protected, [6] and [5] ready, [0] fail |

## Verification
The pending-sequence state is not visible at the ports. A stale or lost pending opcode therefore shows up only when the closing opcode arrives. In that cycle it appears as a busy period that starts when it should not, or that fails to start. The bench checks this through cases of mismatch, early closing and closing sent during busy. A miscounted address index shows up as a wrong `op_row` one cycle after the closing opcode. A busy counter that is off by even one cycle shows up as a wrong length of the low period on `rb_n`. Write-protect faults show up in the same cycle: either a busy period that must not occur, or a wrong value in `status[0]` or `status[7]`.

// File: rtl/lun_seq_pkg.sv
package lun_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PEND = 1'b1
    } seq_state_e;

    localparam logic [7:0] OPC_READ_OPEN   = 8'h00;
    localparam logic [7:0] OPC_READ_SINGLE = 8'h30;
    localparam logic [7:0] OPC_READ_MULTI  = 8'h32;
    localparam logic [7:0] OPC_PROG_OPEN   = 8'h80;
    localparam logic [7:0] OPC_PROG_SINGLE = 8'h10;
    localparam logic [7:0] OPC_PROG_MULTI  = 8'h11;
    localparam logic [7:0] OPC_ERASE_OPEN  = 8'h60;
    localparam logic [7:0] OPC_ERASE_SINGLE = 8'hD0;
    localparam logic [7:0] OPC_ERASE_MULTI = 8'hD1;

endpackage

// File: rtl/lun_opcode_decode.sv
module lun_opcode_decode
    import lun_seq_pkg::*;
(
    input  logic [7:0] code,
    input  op_kind_e   pend_kind,
    output logic       open_hit,
    output op_kind_e   open_kind,
    output logic       close_hit,
    output logic       close_multi
);

    always_comb begin
        open_hit  = 1'b1;
        open_kind = OP_NONE;
        case (code)
            OPC_READ_OPEN:  open_kind = OP_READ;
            OPC_PROG_OPEN:  open_kind = OP_PROG;
            OPC_ERASE_OPEN: open_kind = OP_ERASE;
            default:        open_hit  = 1'b0;
        endcase
    end

    always_comb begin
        close_hit   = 1'b0;
        close_multi = 1'b0;
        case (pend_kind)
            OP_READ: begin
                close_hit   = (code == OPC_READ_SINGLE) || (code == OPC_READ_MULTI);
                close_multi = (code == OPC_READ_MULTI);
            end
            OP_PROG: begin
                close_hit   = (code == OPC_PROG_SINGLE) || (code == OPC_PROG_MULTI);
                close_multi = (code == OPC_PROG_MULTI);
            end
            OP_ERASE: begin
                close_hit   = (code == OPC_ERASE_SINGLE) || (code == OPC_ERASE_MULTI);
                close_multi = (code == OPC_ERASE_MULTI);
            end
            default: begin
                close_hit   = 1'b0;
                close_multi = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lun_addr_gather.sv
module lun_addr_gather #(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int ROW_W    = 8 * ROW_BYTES,
    localparam int CNT_W    = $clog2(COL_BYTES + ROW_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             skip_col,
    input  logic             take,
    input  logic [7:0]       byte_in,
    output logic [ROW_W-1:0] row,
    output logic             complete
);

    localparam logic [CNT_W-1:0] NEED_ALL = CNT_W'(COL_BYTES + ROW_BYTES);
    localparam logic [CNT_W-1:0] NEED_ROW = CNT_W'(ROW_BYTES);
    localparam logic [CNT_W-1:0] COL_OFS  = CNT_W'(COL_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             skip;
        logic [ROW_W-1:0] row;
    } gather_t;

    gather_t          g_d, g_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] first_row;
    logic [CNT_W-1:0] row_idx;

    always_comb begin
        g_d       = g_q;
        need      = g_q.skip ? NEED_ROW : NEED_ALL;
        first_row = g_q.skip ? '0 : COL_OFS;
        row_idx   = g_q.cnt - first_row;
        if (clear) begin
            g_d.cnt  = '0;
            g_d.skip = skip_col;
            g_d.row  = '0;
        end else if (take && (g_q.cnt < need)) begin
            g_d.cnt = g_q.cnt + 1'b1;
            if (g_q.cnt >= first_row) begin
                for (int i = 0; i < ROW_BYTES; i++) begin
                    if (row_idx == CNT_W'(i)) begin
                        g_d.row[8*i +: 8] = byte_in;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign row      = g_q.row;
    assign complete = (g_q.cnt == need);

endmodule

// File: rtl/lun_busy_timer.sv
module lun_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/nand_lun_seq.sv
module nand_lun_seq
    import lun_seq_pkg::*;
#(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    parameter int READ_CYC  = 20,
    parameter int PROG_CYC  = 45,
    parameter int ERASE_CYC = 70,
    localparam int ROW_W    = 8 * ROW_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic             addr_valid,
    input  logic [7:0]       addr_byte,
    input  logic             wp_n,
    output logic             rb_n,
    output logic [1:0]       op_kind,
    output logic             op_multi,
    output logic [ROW_W-1:0] op_row,
    output logic [7:0]       status
);

    localparam int MAX_RP  = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
    localparam int MAX_CYC = (MAX_RP > ERASE_CYC) ? MAX_RP : ERASE_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        op_kind_e         pend;
        op_kind_e         kind;
        logic             multi;
        logic [ROW_W-1:0] row;
        logic             fail;
        logic             wp;
    } seq_t;

    seq_t             s_d, s_q;
    logic             busy;
    logic             open_hit, close_hit, close_multi;
    op_kind_e         open_kind;
    logic             g_clear, g_skip, g_take, g_complete;
    logic [ROW_W-1:0] g_row;
    logic             t_load;
    logic [TMR_W-1:0] t_val;

    lun_opcode_decode i_decode (
        .code        (cmd_code),
        .pend_kind   (s_q.pend),
        .open_hit    (open_hit),
        .open_kind   (open_kind),
        .close_hit   (close_hit),
        .close_multi (close_multi)
    );

    lun_addr_gather #(
        .COL_BYTES (COL_BYTES),
        .ROW_BYTES (ROW_BYTES)
    ) i_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (g_clear),
        .skip_col (g_skip),
        .take     (g_take),
        .byte_in  (addr_byte),
        .row      (g_row),
        .complete (g_complete)
    );

    lun_busy_timer #(
        .CNT_W (TMR_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .busy     (busy)
    );

    always_comb begin
        s_d     = s_q;
        s_d.wp  = wp_n;
        g_clear = 1'b0;
        g_skip  = 1'b0;
        g_take  = 1'b0;
        t_load  = 1'b0;
        case (s_q.pend)
            OP_PROG:  t_val = TMR_W'(PROG_CYC);
            OP_ERASE: t_val = TMR_W'(ERASE_CYC);
            default:  t_val = TMR_W'(READ_CYC);
        endcase
        if (!busy) begin
            if (cmd_valid) begin
                if (open_hit) begin
                    s_d.st   = SEQ_PEND;
                    s_d.pend = open_kind;
                    g_clear  = 1'b1;
                    g_skip   = (open_kind == OP_ERASE);
                end else begin
                    s_d.st   = SEQ_IDLE;
                    s_d.pend = OP_NONE;
                    if ((s_q.st == SEQ_PEND) && close_hit && g_complete) begin
                        if ((s_q.pend != OP_READ) && !wp_n) begin
                            s_d.fail = 1'b1;
                        end else begin
                            t_load    = 1'b1;
                            s_d.kind  = s_q.pend;
                            s_d.multi = close_multi;
                            s_d.row   = g_row;
                            s_d.fail  = 1'b0;
                        end
                    end
                end
            end else if (addr_valid && (s_q.st == SEQ_PEND)) begin
                g_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= SEQ_IDLE;
            s_q.pend  <= OP_NONE;
            s_q.kind  <= OP_NONE;
            s_q.multi <= 1'b0;
            s_q.row   <= '0;
            s_q.fail  <= 1'b0;
            s_q.wp    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rb_n     = ~busy;
    assign op_kind  = s_q.kind;
    assign op_multi = s_q.multi;
    assign op_row   = s_q.row;
    assign status   = {s_q.wp, ~busy, ~busy, 4'b0000, s_q.fail};

endmodule

// File: rtl/lun_seq_checker.sv
module lun_seq_checker #(
    parameter int ROW_W     = 24,
    parameter int READ_CYC  = 20,
    parameter int PROG_CYC  = 45,
    parameter int ERASE_CYC = 70
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wp_n,
    input logic             rb_n,
    input logic [1:0]       op_kind,
    input logic             op_multi,
    input logic [ROW_W-1:0] op_row,
    input logic             ready_hi,
    input logic             ready_lo,
    input logic             fail_bit
);

    logic [31:0] low_cnt;
    logic [31:0] exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!rb_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    always_comb begin
        case (op_kind)
            2'd2:    exp_len = PROG_CYC;
            2'd3:    exp_len = ERASE_CYC;
            default: exp_len = READ_CYC;
        endcase
    end

    AST_START_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> (op_kind != 2'd0));                                   // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_n) |-> (low_cnt == exp_len));                                // R5

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |=> ($stable(op_kind) && $stable(op_multi) && $stable(op_row))); // R6

    AST_PROTECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rb_n) && (op_kind != 2'd1)) |-> $past(wp_n));                  // R9

    AST_FAIL_NEEDS_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_bit) |-> (!$past(wp_n) && rb_n));                          // R9

    AST_READY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_hi == rb_n) && (ready_lo == rb_n));                            // R10

    AST_START_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> !fail_bit);                                           // R10

endmodule

bind nand_lun_seq lun_seq_checker #(
    .ROW_W     (ROW_W),
    .READ_CYC  (READ_CYC),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) i_lun_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .rb_n     (rb_n),
    .op_kind  (op_kind),
    .op_multi (op_multi),
    .op_row   (op_row),
    .ready_hi (status[6]),
    .ready_lo (status[5]),
    .fail_bit (status[0])
);

// File: tb/test_nand_lun_seq.sv
module test_nand_lun_seq;

    localparam int RD = 20;
    localparam int PG = 45;
    localparam int ER = 70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = 8'h00;
    logic        wp_n = 1'b1;
    logic        rb_n;
    logic [1:0]  op_kind;
    logic        op_multi;
    logic [23:0] op_row;
    logic [7:0]  status;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0]  kind;
        logic        multi;
        logic [23:0] row;
        int          cyc;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    nand_lun_seq #(
        .COL_BYTES (2),
        .ROW_BYTES (3),
        .READ_CYC  (RD),
        .PROG_CYC  (PG),
        .ERASE_CYC (ER)
    ) i_nand_lun_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .wp_n       (wp_n),
        .rb_n       (rb_n),
        .op_kind    (op_kind),
        .op_multi   (op_multi),
        .op_row     (op_row),
        .status     (status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] b);
        addr_valid = 1'b1;
        addr_byte  = b;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic do_seq(input logic [7:0] first, input int n_addr,
                          input logic [39:0] bytes, input logic [7:0] second);
        send_cmd(first);
        for (int i = 0; i < n_addr; i++) send_addr(bytes[8*i +: 8]);
        send_cmd(second);
    endtask

    task automatic expect_op(input logic [1:0] k, input logic m,
                             input logic [23:0] r, input int c);
        exp_t e;
        e.kind = k; e.multi = m; e.row = r; e.cyc = c;
        exp_q.push_back(e);
    endtask

    task automatic wait_ready();
        while (rb_n !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops one expected item on each busy start, then times the busy window
    initial begin
        logic prev;
        bit   active;
        int   lowcnt;
        exp_t cur;
        prev = 1'b1; active = 0; lowcnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!rb_n && prev) begin
                    if (exp_q.size() == 0) begin
                        check("R7 unexpected busy start", 32'd1, 32'd0);
                        active = 0;
                    end else begin
                        cur = exp_q.pop_front();
                        check("R2/R3/R4 op_kind", {30'd0, op_kind}, {30'd0, cur.kind});
                        check("R2/R3/R4 op_multi", {31'd0, op_multi}, {31'd0, cur.multi});
                        check("R11 op_row", {8'd0, op_row}, {8'd0, cur.row});
                        active = 1;
                    end
                    lowcnt = 1;
                end else if (!rb_n) begin
                    lowcnt++;
                end else if (!prev && active) begin
                    check("R5 busy length", lowcnt, cur.cyc);
                    active = 0;
                end
                prev = rb_n;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 rb_n", {31'd0, rb_n}, 32'd1);
        check("R1 op_kind", {30'd0, op_kind}, 32'd0);
        check("R1 op_row", {8'd0, op_row}, 32'd0);
        check("R10 status idle", {24'd0, status}, 32'hE0);

        // R2 single-plane read, status while busy
        expect_op(2'd1, 1'b0, 24'h9A7856, RD);
        do_seq(8'h00, 5, 40'h9A78563412, 8'h30);
        check("R10 status busy", {24'd0, status}, 32'h80);
        wait_ready();
        // R2 multi-plane read
        expect_op(2'd1, 1'b1, 24'h010203, RD);
        do_seq(8'h00, 5, 40'h010203BBAA, 8'h32);
        wait_ready();
        // R3 program single and multi
        expect_op(2'd2, 1'b0, 24'hC0FFEE, PG);
        do_seq(8'h80, 5, 40'hC0FFEE0000, 8'h10);
        wait_ready();
        expect_op(2'd2, 1'b1, 24'h123456, PG);
        do_seq(8'h80, 5, 40'h1234560102, 8'h11);
        wait_ready();
        // R4 erase, row bytes only
        expect_op(2'd3, 1'b0, 24'h0A0B0C, ER);
        do_seq(8'h60, 3, 40'h00000A0B0C, 8'hD0);
        wait_ready();
        expect_op(2'd3, 1'b1, 24'h778899, ER);
        do_seq(8'h60, 3, 40'h0000778899, 8'hD1);
        wait_ready();

        // R7 mismatched close aborts
        do_seq(8'h00, 5, 40'h1111111111, 8'h10);
        repeat (3) @(negedge clk);
        check("R7 mismatch no busy", {31'd0, rb_n}, 32'd1);
        check("R7 mismatch outputs held", {8'd0, op_row}, 32'h778899);
        // R8 early close aborts; a later lone close does nothing
        do_seq(8'h80, 2, 40'h0000002222, 8'h10);
        send_cmd(8'h10);
        repeat (3) @(negedge clk);
        check("R8 early close no busy", {31'd0, rb_n}, 32'd1);
        check("R8 outputs held", {30'd0, op_kind}, 32'd3);

        // R9 write protect
        wp_n = 1'b0;
        @(negedge clk);
        check("R10 status wp bit", {24'd0, status}, 32'h60);
        do_seq(8'h80, 5, 40'h3333333333, 8'h10);
        check("R9 program blocked status", {24'd0, status}, 32'h61);
        check("R9 program blocked rb_n", {31'd0, rb_n}, 32'd1);
        do_seq(8'h60, 3, 40'h0000444444, 8'hD0);
        repeat (2) @(negedge clk);
        check("R9 erase blocked rb_n", {31'd0, rb_n}, 32'd1);
        check("R9 erase blocked outputs held", {8'd0, op_row}, 32'h778899);
        expect_op(2'd1, 1'b0, 24'h555555, RD);
        do_seq(8'h00, 5, 40'h5555550000, 8'h30);
        wait_ready();
        check("R10 fail cleared by start", {24'd0, status}, 32'h60);
        wp_n = 1'b1;
        @(negedge clk);

        // R6 events during busy ignored
        expect_op(2'd3, 1'b0, 24'h0000AB, ER);
        do_seq(8'h60, 3, 40'h00000000AB, 8'hD0);
        do_seq(8'h00, 5, 40'h6666666666, 8'h30);
        do_seq(8'h60, 3, 40'h0000777777, 8'hD1);
        send_cmd(8'h80);
        wait_ready();
        send_addr(8'h01); send_addr(8'h02); send_addr(8'h03);
        send_cmd(8'hD0);
        repeat (3) @(negedge clk);
        check("R6 no late completion", {31'd0, rb_n}, 32'd1);
        check("R6 outputs held", {8'd0, op_row}, 32'h0000AB);

        // R7 opening opcode restarts; R11 surplus address bytes ignored
        expect_op(2'd3, 1'b1, 24'h332211, ER);
        send_cmd(8'h00);
        do_seq(8'h60, 4, 40'h0044332211, 8'hD1);
        wait_ready();

        repeat (3) @(negedge clk);
        check("R5 all expected ops seen", exp_q.size(), 32'd0);
        report();
    end

endmodule